// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block sits between many peripheral interrupt sources and one CPU interrupt input. Sources are arranged in groups of equal size, and each group drives one CPU line. A few extra CPU lines, such as a timer line, take a single source each and bypass the grouping. Every source input is latched on its rising edge into a pending flag. Each source has its own enable and each CPU line has its own enable. Among all requests that pass both enables, one winner is chosen by fixed rank. The winner is presented to the CPU as a vector code.

When the CPU accepts the request, three things happen: the winner's flag clears, its group is blocked by an acknowledge bit, and a global mask stops all further requests. The mask lifts on the return-from-interrupt strobe. Software can also lift it early to allow nesting. A group stays blocked until software writes its acknowledge bit. A small register port gives software the enables, the flags, the acknowledge bits and the mask release.

Groups and members are numbered from 0. Register map, with F = next power of two at or above the group count (16 by default) and C = 2F:
- Address g (g < group count): source enables of group g, bit m for member m.
- Address F+g: pending flags of group g. A read returns them; a write of 1 to a bit clears that flag.
- Address C: CPU line enables. Bit g is group line g; bit (group count + d) is direct line d.
- Address C+1: group acknowledge bits. A read returns them; a write of 1 to a bit clears it.
- Address C+2: direct-line flags. A read returns them; a write of 1 to a bit clears that flag.
- Address C+3: bit 0 reads the global mask; a write with bit 0 = 1 clears the mask.

Top module: `gpic_top`

## Requirements
- R1: A source flag sets on the clock after its input goes from 0 to 1, whatever its enables. It stays set after the input falls. An input that stays high does not set the flag again once the flag has been cleared.
- R2: A group source raises irq_o only when both its source enable and its group's line enable are 1. A direct source raises irq_o only when its line enable is 1. The vector for member m of group g is g*GROUP_SIZE+m. The vector for direct line d is NUM_GROUPS*GROUP_SIZE+d.
- R3: Among eligible group lines, the lowest group number wins, whatever order the flags arrived in.
- R4: Within the winning group, the lowest enabled pending member wins, whatever the arrival order.
- R5: Direct lines rank below every group line. Among direct lines, the lowest index wins.
- R6: An accepted request (irq_accept_i while irq_o is 1) clears that source's flag and sets the global mask. irq_o then stays low while the mask is set, even with higher-ranked requests pending.
- R7: irq_return_i clears the global mask. A register write of 1 to mask bit 0 also clears it, which allows nesting.
- R8: Accepting a group source sets that group's acknowledge bit. The group makes no request while the bit is set, and other lines are still served. A register write of 1 to the bit clears it.
- R9: Writing 1 to a flag bit through the register port clears that flag. Bits written as 0 leave their flags unchanged.
- R10: After reset, irq_o is 0 and every enable, flag, acknowledge bit and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_src_i | input | NUM_GROUPS*GROUP_SIZE | Group source inputs; bit g*GROUP_SIZE+m is member m of group g |
| dir_src_i | input | NUM_DIRECT | Direct-line source inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_o | output | 1 | Request to the CPU |
| irq_vec_o | output | VEC_W | Vector code of the current winner |
| irq_accept_i | input | 1 | CPU takes the presented request |
| irq_return_i | input | 1 | Return-from-interrupt strobe |

## Verification
The arbitration is driven with several patterns. In one, flags arrive with the lower-ranked source first, which tells fixed rank apart from arrival order at both the group level and the member level. In another, enable patterns leave exactly one of the two enables open, which separates the two enable gates. Accept sequences with higher-ranked requests pending separate a working global mask from a leaking one. Returning through the strobe or through the register write separates the two mask release paths. Keeping an acknowledge bit set while other groups and direct lines pend shows that blocking is per group and not global. A long stretch of seeded random pulses, enable writes, accepts, releases and flag clears is compared against a bench model of the flags, the acknowledge bits and the mask.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
   // Offsets of the control registers above the control base address
   typedef enum logic [1:0] {
      CTL_LINE_EN  = 2'd0,
      CTL_GRP_ACK  = 2'd1,
      CTL_DIR_FLAG = 2'd2,
      CTL_GMASK    = 2'd3
   } ctl_reg_e;
endpackage

// File: rtl/gpic_edge_flags.sv
module gpic_edge_flags #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] prev_q;
   logic [N-1:0] flag_q;
   logic [N-1:0] rise;

   assign rise   = src_i & ~prev_q;
   assign flag_o = flag_q;

   // a new edge outranks a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= src_i;
         flag_q <= (flag_q & ~clr_i) | rise;
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_chk
      assert_edge_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i[k] && !prev_q[k]) |=> flag_o[k]);
      assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[k] && !(src_i[k] && !prev_q[k])) |=> !flag_o[k]);
   end
endmodule

// File: rtl/gpic_prio_enc.sv
module gpic_prio_enc #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N < 2) begin : g_bad_n
      $error("gpic_prio_enc: N must be at least 2");
   end

   // lowest set index wins
   always_comb begin
      valid_o = |req_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/gpic_regs.sv
module gpic_regs
   import gpic_pkg::*;
#(
   parameter int unsigned NG        = 12,
   parameter int unsigned GS        = 8,
   parameter int unsigned ND        = 3,
   parameter int unsigned DATA_W    = 15,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned FLAG_BASE = 16,
   parameter int unsigned CTRL_BASE = 32,
   parameter int unsigned NL        = NG + ND
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NG*GS-1:0]  grp_flag_i,
   input  logic [ND-1:0]     dir_flag_i,
   input  logic              accept_i,
   input  logic [NG-1:0]     acc_grp_oh_i,
   input  logic              return_i,
   output logic [NG*GS-1:0]  src_en_o,
   output logic [NL-1:0]     line_en_o,
   output logic [NG-1:0]     ack_o,
   output logic              gmask_o,
   output logic [NG*GS-1:0]  sw_clr_grp_o,
   output logic [ND-1:0]     sw_clr_dir_o
);
   logic [NG*GS-1:0] src_en_q;
   logic [NL-1:0]    line_en_q;
   logic [NG-1:0]    ack_q;
   logic             gmask_q;
   logic             wr_line, wr_ack, wr_dflag, wr_mask;
   logic [NG-1:0]    ack_clr;

   function automatic logic [ADDR_W-1:0] ctl_addr(ctl_reg_e sel);
      return ADDR_W'(CTRL_BASE) + ADDR_W'(sel);
   endfunction

   assign wr_line  = wr_i && (addr_i == ctl_addr(CTL_LINE_EN));
   assign wr_ack   = wr_i && (addr_i == ctl_addr(CTL_GRP_ACK));
   assign wr_dflag = wr_i && (addr_i == ctl_addr(CTL_DIR_FLAG));
   assign wr_mask  = wr_i && (addr_i == ctl_addr(CTL_GMASK));
   assign ack_clr  = wr_ack ? wdata_i[NG-1:0] : '0;

   assign src_en_o  = src_en_q;
   assign line_en_o = line_en_q;
   assign ack_o     = ack_q;
   assign gmask_o   = gmask_q;

   always_comb begin
      sw_clr_grp_o = '0;
      for (int g = 0; g < NG; g++) begin
         if (wr_i && (addr_i == ADDR_W'(FLAG_BASE + g)))
            sw_clr_grp_o[g*GS +: GS] = wdata_i[GS-1:0];
      end
      sw_clr_dir_o = wr_dflag ? wdata_i[ND-1:0] : '0;
   end

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < NG; g++) begin
         if (addr_i == ADDR_W'(g))
            rdata_o = DATA_W'(src_en_q[g*GS +: GS]);
         if (addr_i == ADDR_W'(FLAG_BASE + g))
            rdata_o = DATA_W'(grp_flag_i[g*GS +: GS]);
      end
      if (addr_i == ctl_addr(CTL_LINE_EN))  rdata_o = DATA_W'(line_en_q);
      if (addr_i == ctl_addr(CTL_GRP_ACK))  rdata_o = DATA_W'(ack_q);
      if (addr_i == ctl_addr(CTL_DIR_FLAG)) rdata_o = DATA_W'(dir_flag_i);
      if (addr_i == ctl_addr(CTL_GMASK))    rdata_o = DATA_W'(gmask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en_q  <= '0;
         line_en_q <= '0;
         ack_q     <= '0;
         gmask_q   <= 1'b0;
      end else begin
         for (int g = 0; g < NG; g++) begin
            if (wr_i && (addr_i == ADDR_W'(g)))
               src_en_q[g*GS +: GS] <= wdata_i[GS-1:0];
         end
         if (wr_line) line_en_q <= wdata_i[NL-1:0];
         // a new acceptance outranks a software clear of the same bit
         ack_q <= (ack_q & ~ack_clr) | acc_grp_oh_i;
         if (accept_i)
            gmask_q <= 1'b1;
         else if (return_i || (wr_mask && wdata_i[0]))
            gmask_q <= 1'b0;
      end
   end

   assert_accept_sets_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_grp_oh_i != '0) |=> ((ack_o & $past(acc_grp_oh_i)) != '0));
   assert_return_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (return_i && !accept_i) |=> !gmask_o);
   assert_accept_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept_i |=> gmask_o);
endmodule

// File: rtl/gpic_top.sv
module gpic_top #(
   parameter int unsigned NUM_GROUPS = 12,
   parameter int unsigned GROUP_SIZE = 8,
   parameter int unsigned NUM_DIRECT = 3,
   parameter int unsigned DATA_W     = (NUM_GROUPS + NUM_DIRECT > GROUP_SIZE) ?
                                       (NUM_GROUPS + NUM_DIRECT) : GROUP_SIZE,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned VEC_W      = $clog2(NUM_GROUPS * GROUP_SIZE + NUM_DIRECT)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_GROUPS*GROUP_SIZE-1:0] grp_src_i,
   input  logic [NUM_DIRECT-1:0]            dir_src_i,
   input  logic                             reg_wr_i,
   input  logic [ADDR_W-1:0]                reg_addr_i,
   input  logic [DATA_W-1:0]                reg_wdata_i,
   output logic [DATA_W-1:0]                reg_rdata_o,
   output logic                             irq_o,
   output logic [VEC_W-1:0]                 irq_vec_o,
   input  logic                             irq_accept_i,
   input  logic                             irq_return_i
);
   localparam int unsigned NG        = NUM_GROUPS;
   localparam int unsigned GS        = GROUP_SIZE;
   localparam int unsigned ND        = NUM_DIRECT;
   localparam int unsigned NS        = NG * GS;
   localparam int unsigned NL        = NG + ND;
   localparam int unsigned MEM_W     = $clog2(GS);
   localparam int unsigned LINE_W    = $clog2(NL);
   localparam int unsigned FLAG_BASE = 1 << $clog2(NG);
   localparam int unsigned CTRL_BASE = 2 * FLAG_BASE;
   localparam logic [GS-1:0] GS_ONE  = 1;
   localparam logic [NL-1:0] NL_ONE  = 1;

   if (GS < 2 || NG < 1 || ND < 1) begin : g_bad_shape
      $error("gpic_top: need GROUP_SIZE >= 2, NUM_GROUPS >= 1, NUM_DIRECT >= 1");
   end
   if (DATA_W < GS || DATA_W < NL) begin : g_bad_data
      $error("gpic_top: DATA_W too narrow for enables");
   end
   if (ADDR_W < $clog2(CTRL_BASE + 4)) begin : g_bad_addr
      $error("gpic_top: ADDR_W too narrow for register map");
   end
   if (VEC_W < $clog2(NS + ND)) begin : g_bad_vec
      $error("gpic_top: VEC_W too narrow for vector codes");
   end

   logic [NS-1:0]     grp_flag, grp_req, src_en, sw_clr_grp, acc_clr_grp;
   logic [ND-1:0]     dir_flag, sw_clr_dir, acc_clr_dir;
   logic [NL-1:0]     line_en, eligible, below_win;
   logic [NG-1:0]     ack, grp_valid, acc_grp_oh;
   logic [MEM_W-1:0]  grp_idx [NG];
   logic              gmask, win_valid, accept_fire;
   logic [LINE_W-1:0] win_line;
   logic [VEC_W-1:0]  vec;

   gpic_edge_flags #(.N(NS)) u_grp_flags (
      .clk(clk), .rst_n(rst_n), .src_i(grp_src_i),
      .clr_i(sw_clr_grp | acc_clr_grp), .flag_o(grp_flag)
   );

   gpic_edge_flags #(.N(ND)) u_dir_flags (
      .clk(clk), .rst_n(rst_n), .src_i(dir_src_i),
      .clr_i(sw_clr_dir | acc_clr_dir), .flag_o(dir_flag)
   );

   assign grp_req = grp_flag & src_en;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      gpic_prio_enc #(.N(GS), .IDX_W(MEM_W)) u_member_arb (
         .req_i(grp_req[g*GS +: GS]), .valid_o(grp_valid[g]), .idx_o(grp_idx[g])
      );
      assign eligible[g] = line_en[g] & ~ack[g] & grp_valid[g];

      assert_member_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
         grp_valid[g] |-> ((grp_req[g*GS +: GS] & ((GS_ONE << grp_idx[g]) - GS_ONE)) == '0));
   end

   for (genvar d = 0; d < ND; d++) begin : g_dir
      assign eligible[NG+d] = line_en[NG+d] & dir_flag[d];
   end

   gpic_prio_enc #(.N(NL), .IDX_W(LINE_W)) u_line_arb (
      .req_i(eligible), .valid_o(win_valid), .idx_o(win_line)
   );

   assign irq_o       = win_valid & ~gmask;
   assign accept_fire = irq_accept_i & irq_o;
   assign irq_vec_o   = vec;
   assign below_win   = (NL_ONE << win_line) - NL_ONE;

   always_comb begin
      vec         = '0;
      acc_clr_grp = '0;
      acc_clr_dir = '0;
      acc_grp_oh  = '0;
      for (int g = 0; g < NG; g++) begin
         if (win_line == LINE_W'(g)) begin
            vec           = VEC_W'(g * GS) + VEC_W'(grp_idx[g]);
            acc_grp_oh[g] = accept_fire;
            for (int m = 0; m < GS; m++) begin
               if (grp_idx[g] == MEM_W'(m)) acc_clr_grp[g*GS + m] = accept_fire;
            end
         end
      end
      for (int d = 0; d < ND; d++) begin
         if (win_line == LINE_W'(NG + d)) begin
            vec            = VEC_W'(NS + d);
            acc_clr_dir[d] = accept_fire;
         end
      end
   end

   gpic_regs #(
      .NG(NG), .GS(GS), .ND(ND), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .FLAG_BASE(FLAG_BASE), .CTRL_BASE(CTRL_BASE), .NL(NL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
      .grp_flag_i(grp_flag), .dir_flag_i(dir_flag),
      .accept_i(accept_fire), .acc_grp_oh_i(acc_grp_oh), .return_i(irq_return_i),
      .src_en_o(src_en), .line_en_o(line_en), .ack_o(ack), .gmask_o(gmask),
      .sw_clr_grp_o(sw_clr_grp), .sw_clr_dir_o(sw_clr_dir)
   );

   assert_accept_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept_i && irq_o) |=> !irq_o);
   assert_line_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((eligible & below_win) == '0));
   assert_direct_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && (irq_vec_o >= VEC_W'(NS))) |-> (eligible[NG-1:0] == '0));
   assert_win_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((line_en & (NL_ONE << win_line)) != '0));
endmodule

// File: tb/gpic_top_tb.sv
module gpic_top_tb;
   localparam int NG = 12, GS = 8, ND = 3, NS = NG * GS, NL = NG + ND;
   localparam int DW = 15, AW = 6, VW = 7;
   localparam int FB = 16, CB = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] grp_src = '0;
   logic [ND-1:0] dir_src = '0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq;
   logic [VW-1:0] irq_vec;
   logic          irq_accept = 1'b0;
   logic          irq_return = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   bit [NS-1:0] m_flag;
   bit [ND-1:0] m_dflag;
   bit [NS-1:0] m_sen;
   bit [NL-1:0] m_len;
   bit [NG-1:0] m_ack;
   bit          m_mask;

   always #4 clk = ~clk;

   gpic_top u_dut (
      .clk(clk), .rst_n(rst_n), .grp_src_i(grp_src), .dir_src_i(dir_src),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .irq_o(irq), .irq_vec_o(irq_vec),
      .irq_accept_i(irq_accept), .irq_return_i(irq_return)
   );

   function automatic int exp_vec();
      for (int g = 0; g < NG; g++)
         if (m_len[g] && !m_ack[g])
            for (int m = 0; m < GS; m++)
               if (m_flag[g*GS+m] && m_sen[g*GS+m]) return g * GS + m;
      for (int d = 0; d < ND; d++)
         if (m_len[NG+d] && m_dflag[d]) return NS + d;
      return -1;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic check_irq(string req);
      int e;
      int ei;
      @(negedge clk); #1;
      e  = exp_vec();
      ei = (e >= 0 && !m_mask) ? 1 : 0;
      check(req, int'(irq), ei);
      if (ei == 1 && irq) check(req, int'(irq_vec), e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; grp_src = '0; dir_src = '0; reg_wr = 1'b0;
      irq_accept = 1'b0; irq_return = 1'b0;
      m_flag = '0; m_dflag = '0; m_sen = '0; m_len = '0; m_ack = '0; m_mask = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_write(int addr, int data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = DW'(data);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(int addr, output int data);
      @(negedge clk);
      reg_addr = AW'(addr);
      #1 data = int'(reg_rdata);
   endtask

   task automatic set_sen(int g, int val);
      reg_write(g, val);
      m_sen[g*GS +: GS] = GS'(val);
   endtask

   task automatic set_len(int val);
      reg_write(CB, val);
      m_len = NL'(val);
   endtask

   task automatic pulse(bit [NS-1:0] gv, bit [ND-1:0] dv);
      @(negedge clk);
      grp_src = gv; dir_src = dv;
      @(negedge clk);
      grp_src = '0; dir_src = '0;
      m_flag  = m_flag | gv;
      m_dflag = m_dflag | dv;
   endtask

   task automatic accept();
      int e;
      e = exp_vec();
      @(negedge clk);
      irq_accept = 1'b1;
      @(negedge clk);
      irq_accept = 1'b0;
      if (e >= 0 && !m_mask) begin
         if (e < NS) begin
            m_flag[e] = 1'b0;
            m_ack[e / GS] = 1'b1;
         end else begin
            m_dflag[e - NS] = 1'b0;
         end
         m_mask = 1'b1;
      end
   endtask

   task automatic ret();
      @(negedge clk);
      irq_return = 1'b1;
      @(negedge clk);
      irq_return = 1'b0;
      m_mask = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int rd;
      int unused_seed;
      unused_seed = int'($urandom(32'd20240517));

      // R10 reset state
      do_reset();
      check_irq("R10 irq low");
      reg_read(CB, rd);      check("R10 line enables", rd, 0);
      reg_read(0, rd);       check("R10 source enables", rd, 0);
      reg_read(CB + 3, rd);  check("R10 mask", rd, 0);

      // R1 latch on edge, held input does not relatch; R9 clear
      @(negedge clk); grp_src[GS+2] = 1'b1;
      repeat (3) @(negedge clk);
      reg_read(FB + 1, rd);  check("R1 flag latched", rd, 32'h04);
      reg_write(FB + 1, 32'h04);
      repeat (2) @(negedge clk);
      reg_read(FB + 1, rd);  check("R1 held high no relatch", rd, 0);
      @(negedge clk); grp_src[GS+2] = 1'b0;
      pulse(NS'(1) << (GS + 1), '0);
      pulse(NS'(1) << (GS + 2), '0);
      reg_read(FB + 1, rd);  check("R1 flags stay after fall", rd, 32'h06);
      reg_write(FB + 1, 32'h02);
      reg_read(FB + 1, rd);  check("R9 zero bits keep flags", rd, 32'h04);
      reg_write(FB + 1, 32'h04);
      reg_read(FB + 1, rd);  check("R9 cleared", rd, 0);
      m_flag = '0;

      // R2 dual enables and vector code
      pulse(NS'(1) << (3*GS + 5), '0);
      check_irq("R2 no enables");
      set_sen(3, 32'h20);
      check_irq("R2 source enable only");
      check("R2 irq still low", int'(irq), 0);
      set_len(32'h008);
      check_irq("R2 both enables");
      check("R2 vector", int'(irq_vec), 29);

      // R3 group rank beats arrival order
      set_sen(0, 32'hFF);
      set_len(32'h3009);
      pulse(NS'(1) << 6, '0);
      check_irq("R3 lower group wins");
      check("R3 vector", int'(irq_vec), 6);

      // R4 member rank beats arrival order
      pulse(NS'(1) << 2, '0);
      check_irq("R4 lower member wins");
      check("R4 vector", int'(irq_vec), 2);

      // R6 accept masks and clears flag
      accept();
      check_irq("R6 masked after accept");
      check("R6 irq low", int'(irq), 0);
      reg_read(FB, rd);      check("R6 winner flag cleared", rd, 32'h40);
      reg_read(CB + 1, rd);  check("R8 ack set for group 0", rd, 1);

      // R7 return, R8 blocked group skipped
      ret();
      check_irq("R8 other group served");
      check("R8 vector", int'(irq_vec), 29);
      accept();
      pulse('0, 3'b011);
      check_irq("R6 pending waits while masked");
      reg_write(CB + 3, 1);
      m_mask = 1'b0;
      check_irq("R7 software unmask");
      check("R5 direct line 0 first", int'(irq_vec), NS);
      reg_write(CB + 1, 32'h001);
      m_ack[0] = 1'b0;
      check_irq("R5 group beats direct");
      check("R8 ack cleared", int'(irq_vec), 6);

      // randomized phase
      do_reset();
      for (int it = 0; it < 250; it++) begin
         bit [NS-1:0] gv;
         bit [ND-1:0] dv;
         int k;
         gv = '0; dv = '0;
         if ($urandom_range(3) == 0) set_sen(int'($urandom_range(NG - 1)), int'($urandom_range(255)));
         if ($urandom_range(3) == 0) set_len(int'($urandom_range(32767)));
         k = int'($urandom_range(3)) + 1;
         for (int j = 0; j < k; j++) begin
            int s;
            s = int'($urandom_range(NS + ND - 1));
            if (s < NS) gv[s] = 1'b1; else dv[s - NS] = 1'b1;
         end
         pulse(gv, dv);
         check_irq("R3 R4 R5 random arbitration");
         if (irq) begin
            accept();
            check_irq("R6 random accept masks");
            if ($urandom_range(1) == 1) ret();
            else begin
               reg_write(CB + 3, 1);
               m_mask = 1'b0;
            end
            check_irq("R7 random unmask");
         end
         if ($urandom_range(1) == 1) begin
            int msk;
            msk = int'($urandom_range(4095));
            reg_write(CB + 1, msk);
            m_ack = m_ack & ~NG'(msk);
            check_irq("R8 random ack clear");
         end
         if ($urandom_range(4) == 0) begin
            int g;
            int cm;
            g  = int'($urandom_range(NG - 1));
            cm = int'($urandom_range(255));
            reg_write(FB + g, cm);
            m_flag[g*GS +: GS] = m_flag[g*GS +: GS] & ~GS'(cm);
            reg_read(FB + g, rd);
            check("R9 random flag clear", rd, int'(m_flag[g*GS +: GS]));
         end
      end

      summary();
      $finish;
   end
endmodule